// File: doc/BRIEF.md
# Emulated PHY Duplex and Pause Resolver

This block sits where a switch port's MAC would normally meet a PHY. It stands in for that PHY and decides two things for the MAC: whether the port runs full or half duplex, and whether transmit and receive pause are enabled. It has three writable registers: a control register, a pause advertisement register and a manual flow-control register. A small status register shows the resolved result. All four are reached through a simple single-cycle read/write port.

In PHY mode the block runs a pretend auto-negotiation with an emulated partner. That partner always advertises exactly the local pause abilities, so the pause result follows from the local advertisement alone. In MAC mode a real PHY sits outside the chip. Duplex then comes from comparing a duplex pin with a polarity strap, and the pause enables come from the manual register. A self-clearing soft reset restores the register defaults and holds a reset output high for a fixed, parameterised number of cycles (about 102 us).

Register map (2-bit address): 0 = control {bit2 soft_reset, bit1 duplex_full, bit0 an_enable}; 1 = advertisement {bit1 asym_pause, bit0 sym_pause}; 2 = manual flow control {bit2 rx_pause, bit1 tx_pause, bit0 manual_select}; 3 = status, read-only {bit2 rx_pause, bit1 tx_pause, bit0 duplex_full}. Unused bits read 0.

Top module: `emu_phy_resolver`

## Requirements
- R1: After rst_ni the registers read control=0x03 (an_enable=1, duplex_full=1, soft_reset=0), advertisement=0x03 and manual=0x00, and emu_rst_o is 0.
- R2: In PHY mode with an_enable=1 and manual_select=0, duplex is full. sym_pause=1 gives tx and rx pause both 1. asym_pause=1 with sym_pause=0 gives tx pause only. Neither bit set gives no pause.
- R3: When mac_mode_i=1, or an_enable=0, or manual_select=1, the pause enables equal the manual register's tx_pause and rx_pause bits, subject to R7.
- R4: Writing the manual register leaves the advertisement register unchanged.
- R5: In MAC mode with an_enable=1, duplex_full_o is 1 exactly when duplex_pin_i equals duplex_pol_i. It follows the pins in the same cycle and is never latched.
- R6: With an_enable=0, duplex_full_o equals the control register's duplex_full bit, in either mode.
- R7: While duplex is half, tx_pause_o and rx_pause_o are both 0.
- R8: Writing control with bit2=1 restores all register defaults. emu_rst_o and the soft_reset bit then read 1 for exactly RST_US*CLK_MHZ cycles after the write edge, and 0 afterwards.
- R9: Register writes made while the soft reset is in progress are ignored.
- R10: Address 3 reads {rx_pause_o, tx_pause_o, duplex_full_o} in bits 2:0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| mac_mode_i | input | 1 | 1 = MAC mode, 0 = PHY mode |
| duplex_pin_i | input | 1 | Duplex indication from external PHY |
| duplex_pol_i | input | 1 | Duplex polarity strap |
| duplex_full_o | output | 1 | Resolved duplex, 1 = full |
| tx_pause_o | output | 1 | Transmit pause enable |
| rx_pause_o | output | 1 | Receive pause enable |
| emu_rst_o | output | 1 | Reset for the emulation logic, high during soft reset |

## Verification
The bench goes through every combination of mode, control bits, advertisement bits, manual bits and the two duplex inputs, and compares the outputs and the status register with a model of the priority rules. A design that let auto-negotiation win over manual_select, or that ignored MAC mode when choosing the pause source, would give wrong pause enables in those combinations. A design that latched the duplex pin, or that leaked pause while in half duplex, would also fail them. The soft-reset window is measured cycle by cycle, so an off-by-one in the counter shows up. Writes made during the window, writes to the status address and manual-register writes are each followed by read-back, which catches a design that lets any of them corrupt state.

// File: rtl/emu_phy_pkg.sv
`timescale 1ns/1ps
package emu_phy_pkg;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_ADV  = 2'd1;
  localparam logic [AW-1:0] A_MFC  = 2'd2;
  localparam logic [AW-1:0] A_STAT = 2'd3;

  typedef struct packed { logic dup_full; logic an_en; } ctrl_t;
  typedef struct packed { logic asym; logic sym; } adv_t;
  typedef struct packed { logic rx; logic tx; logic sel; } mfc_t;

  localparam ctrl_t CTRL_DEF = '{dup_full: 1'b1, an_en: 1'b1};
  localparam adv_t  ADV_DEF  = '{asym: 1'b1, sym: 1'b1};
  localparam mfc_t  MFC_DEF  = '{rx: 1'b0, tx: 1'b0, sel: 1'b0};
endpackage

// File: rtl/emu_phy_regs.sv
`timescale 1ns/1ps
module emu_phy_regs
  import emu_phy_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_MHZ = 250,
  parameter int RST_US  = 102
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output adv_t          adv_o,
  output mfc_t          mfc_o,
  output logic          busy_o
);
  localparam int RST_CYCLES = CLK_MHZ * RST_US;
  localparam int CW = $clog2(RST_CYCLES + 1);

  ctrl_t ctrl_q;
  adv_t  adv_q;
  mfc_t  mfc_q;
  logic  busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DEF;
      adv_q  <= ADV_DEF;
      mfc_q  <= MFC_DEF;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      // writes are dropped while the soft reset runs
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) busy_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL: begin
          if (wdata_i[2]) begin
            ctrl_q <= CTRL_DEF;
            adv_q  <= ADV_DEF;
            mfc_q  <= MFC_DEF;
            busy_q <= 1'b1;
            cnt_q  <= CW'(RST_CYCLES - 1);
          end else begin
            ctrl_q <= ctrl_t'(wdata_i[1:0]);
          end
        end
        A_ADV:   adv_q <= adv_t'(wdata_i[1:0]);
        A_MFC:   mfc_q <= mfc_t'(wdata_i[2:0]);
        default: ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;
  assign mfc_o  = mfc_q;
  assign busy_o = busy_q;

  p_adv_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MFC) |=> $stable(adv_q));
  p_busy_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> ($stable(adv_q) && $stable(mfc_q) && $stable(ctrl_q)));
  p_busy_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> !busy_q);
  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && wr_en_i && addr_i == A_CTRL && wdata_i[2]) |=> (busy_q && adv_q == ADV_DEF));
endmodule

// File: rtl/emu_phy_resolve.sv
`timescale 1ns/1ps
module emu_phy_resolve
  import emu_phy_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  adv_t  adv_i,
  input  mfc_t  mfc_i,
  input  logic  mac_mode_i,
  input  logic  duplex_pin_i,
  input  logic  duplex_pol_i,
  output logic  duplex_full_o,
  output logic  tx_pause_o,
  output logic  rx_pause_o
);
  logic use_manual, an_tx, an_rx;

  always_comb begin
    if (!ctrl_i.an_en)   duplex_full_o = ctrl_i.dup_full;
    else if (mac_mode_i) duplex_full_o = (duplex_pin_i == duplex_pol_i);
    else                 duplex_full_o = 1'b1; // emulated partner is full duplex
  end

  // emulated partner mirrors local advertisement
  assign an_tx      = adv_i.sym | adv_i.asym;
  assign an_rx      = adv_i.sym;
  assign use_manual = mac_mode_i | ~ctrl_i.an_en | mfc_i.sel;

  assign tx_pause_o = duplex_full_o & (use_manual ? mfc_i.tx : an_tx);
  assign rx_pause_o = duplex_full_o & (use_manual ? mfc_i.rx : an_rx);
endmodule

// File: rtl/emu_phy_resolver.sv
`timescale 1ns/1ps
module emu_phy_resolver
  import emu_phy_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_MHZ = 250,
  parameter int RST_US  = 102
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          mac_mode_i,
  input  logic          duplex_pin_i,
  input  logic          duplex_pol_i,
  output logic          duplex_full_o,
  output logic          tx_pause_o,
  output logic          rx_pause_o,
  output logic          emu_rst_o
);
  ctrl_t ctrl;
  adv_t  adv;
  mfc_t  mfc;
  logic  busy;

  emu_phy_regs #(.DW(DW), .CLK_MHZ(CLK_MHZ), .RST_US(RST_US)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .adv_o(adv), .mfc_o(mfc), .busy_o(busy)
  );

  emu_phy_resolve u_resolve (
    .ctrl_i(ctrl), .adv_i(adv), .mfc_i(mfc),
    .mac_mode_i, .duplex_pin_i, .duplex_pol_i,
    .duplex_full_o, .tx_pause_o, .rx_pause_o
  );

  assign emu_rst_o = busy;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[2:0] = {busy, ctrl};
      A_ADV:   rdata_o[1:0] = adv;
      A_MFC:   rdata_o[2:0] = mfc;
      default: rdata_o[2:0] = {rx_pause_o, tx_pause_o, duplex_full_o};
    endcase
  end

  p_half_no_pause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !duplex_full_o |-> (!tx_pause_o && !rx_pause_o));
  p_mac_dup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_mode_i && ctrl.an_en) |-> (duplex_full_o == (duplex_pin_i == duplex_pol_i)));
  p_manual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mac_mode_i || !ctrl.an_en || mfc.sel) && duplex_full_o) |->
      (tx_pause_o == mfc.tx && rx_pause_o == mfc.rx));
  p_forced_dup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.an_en |-> (duplex_full_o == ctrl.dup_full));
endmodule

// File: tb/emu_phy_resolver_bench.sv
`timescale 1ns/1ps
module emu_phy_resolver_bench;
  localparam int DW = 8;
  localparam int CLK_MHZ = 250;
  localparam int RST_US = 1;
  localparam int RST_CYC = CLK_MHZ * RST_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] wdata = '0, rdata;
  logic mac_mode = 1'b0, dpin = 1'b0, dpol = 1'b0;
  logic dup, txp, rxp, erst;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  emu_phy_resolver #(.DW(DW), .CLK_MHZ(CLK_MHZ), .RST_US(RST_US)) u_emu_phy_resolver (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mac_mode_i(mac_mode), .duplex_pin_i(dpin), .duplex_pol_i(dpol),
    .duplex_full_o(dup), .tx_pause_o(txp), .rx_pause_o(rxp), .emu_rst_o(erst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rd(2'd3, v);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R1 ctrl", v, 3);
    rd(2'd1, v); check("R1 adv", v, 3);
    rd(2'd2, v); check("R1 mfc", v, 0);
    check("R1 emu_rst", int'(erst), 0);

    for (int c = 0; c < 1024; c++) begin
      logic m, an, db, sel, mtx, mrx, sym, asym, pin, pol;
      logic edup, etx, erx, man;
      {m, an, db, sel, mtx, mrx, sym, asym, pin, pol} = c[9:0];
      wr(2'd0, {6'd0, db, an});
      wr(2'd1, {6'd0, asym, sym});
      wr(2'd2, {5'd0, mrx, mtx, sel});
      mac_mode = m; dpin = pin; dpol = pol;
      #1;
      edup = !an ? db : (m ? (pin == pol) : 1'b1);
      man  = m || !an || sel;
      etx  = edup & (man ? mtx : (sym | asym));
      erx  = edup & (man ? mrx : sym);
      if (!an) check("R6 forced duplex", int'(dup), int'(edup));
      else if (m) check("R5 pin vs strap duplex", int'(dup), int'(edup));
      else check("R2 phy duplex", int'(dup), int'(edup));
      if (!edup) check("R7 half no pause", int'({rxp, txp}), 0);
      else if (man) check("R3 manual pause", int'({rxp, txp}), int'({erx, etx}));
      else check("R2 negotiated pause", int'({rxp, txp}), int'({erx, etx}));
      rd(2'd3, v); check("R10 status", v, int'({erx, etx, edup}));
      rd(2'd1, v); check("R4 adv kept", v, int'({asym, sym}));
      if (an && m) begin
        // R5: toggle pin, no clock edge, duplex follows
        dpin = ~pin; #1;
        check("R5 follows pin", int'(dup), int'(~pin == pol));
      end
    end

    // R10 writes to status ignored
    mac_mode = 1'b0;
    wr(2'd0, 8'h03); wr(2'd1, 8'h02); wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    rd(2'd0, v); check("R10 ctrl after status write", v, 3);
    rd(2'd1, v); check("R10 adv after status write", v, 2);
    rd(2'd2, v); check("R10 mfc after status write", v, 0);
    rd(2'd3, v); check("R10 status asym only", v, 3);

    // R8 soft reset window and defaults
    wr(2'd1, 8'h00); wr(2'd2, 8'h07); wr(2'd0, 8'h02);
    wr(2'd0, 8'h04);
    rd(2'd0, v); check("R8 soft bit set", v, 7);
    rd(2'd1, v); check("R8 adv default", v, 3);
    rd(2'd2, v); check("R8 mfc default", v, 0);
    n = 0;
    while (erst && n < 10 * RST_CYC) begin n++; @(negedge clk); end
    check("R8 window length", n, RST_CYC);
    rd(2'd0, v); check("R8 soft bit cleared", v, 3);

    // R9 writes during soft reset are dropped
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h07); wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    rd(2'd2, v); check("R9 mfc write dropped", v, 0);
    rd(2'd1, v); check("R9 adv write dropped", v, 3);
    rd(2'd0, v); check("R9 ctrl write dropped", v, 7);
    while (erst) @(negedge clk);
    wr(2'd2, 8'h07);
    rd(2'd2, v); check("R9 write accepted after window", v, 7);

    finish_run();
  end
endmodule